// File: doc/BRIEF.md
# Even-Ratio Programmable Clock Divider

The block derives a slower clock from its input clock by dividing it by an even ratio chosen at run time. The ratio is held as a small divider field N and is always 2*(N+1). A 5-bit field gives ratios from 2 to 64. The output stays high for N+1 input cycles and low for N+1 input cycles, so its duty cycle is exactly one half.

Software asks for a ratio by presenting a requested ratio together with a one-cycle request strobe. A request for an even ratio that the field can encode is accepted, and the field then holds half the ratio minus one. A request for an odd ratio, for zero, or for a ratio above the largest one is rejected, and the field keeps its value. Either way a one-cycle status pulse reports the outcome.

A newly programmed field is not used at once. It waits until the next rising edge of the output clock, so the output never produces a shortened phase. The ratio in use is read back on its own port. A separate combinational helper answers rounding queries with the nearest even ratio at or above a requested value.

Top module: `even_clk_div`

## Requirements
- R1: While `rst` is sampled high, and in the cycle after it, `clk_div_o` is 0, `div_field` is 0, `active_ratio` is 2, and both `set_ok` and `set_err` are 0.
- R2: `active_ratio` always equals 2*(n+1), where n is the field value in use, so it ranges from 2 to 64.
- R3: `clk_div_o` holds each level for exactly n+1 input cycles, where n is the field value in use.
- R4: A request with an even ratio R, 2 <= R <= 64, sets `div_field` to R/2-1 in the next cycle, and `set_ok` is 1 for that one cycle.
- R5: A request with an odd ratio raises `set_err` for one cycle and leaves `div_field` unchanged.
- R6: A request with ratio 0, or with a ratio above 64, raises `set_err` for one cycle and leaves `div_field` unchanged.
- R7: A changed `div_field` reaches `active_ratio` and the output timing only at the next rising edge of `clk_div_o`. Until that edge the old ratio stays in use.
- R8: `round_rate` equals `round_req`+1 with bit 0 cleared, is combinational, and is one bit wider than `round_req`.
- R9: In a cycle that follows no request, `set_ok` and `set_err` are both 0, and the two are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| set_valid | input | 1 | One-cycle strobe for a ratio request |
| set_ratio | input | RATIO_W | Requested divide ratio |
| set_ok | output | 1 | Pulse: the previous request was accepted |
| set_err | output | 1 | Pulse: the previous request was rejected |
| div_field | output | FIELD_W | Programmed divider field N |
| active_ratio | output | RATIO_W | Divide ratio currently driving the output |
| round_req | input | RATIO_W | Ratio for a rounding query |
| round_rate | output | RATIO_W+1 | Even ratio at or above `round_req` |
| clk_div_o | output | 1 | Divided clock output |

## Verification
The divider runs at the reset ratio of 2, at a middle ratio, and at both ends of the range (2 and 64). These cases separate phase-length errors from errors in the readback encoding. The rejection paths use an odd ratio, zero, and a value just above the top. These show whether each illegal class is caught and leaves the field alone. Requests arrive in the middle of a long period, including two in a row, which shows whether a new ratio is adopted only at a rising edge and whether the last request wins. Rounding queries cover zero, odd values, even values and the all-ones input, which exercises the carry into the extra bit.

// File: rtl/even_clk_div_pkg.sv
package even_clk_div_pkg;

    typedef enum logic [1:0] {
        ST_NONE = 2'd0,
        ST_DONE = 2'd1,
        ST_REJ  = 2'd2
    } req_st_e;

    // Even, non-zero, and within what a field of fw bits encodes (2*2^fw).
    function automatic logic ratio_legal(input int unsigned r, input int fw);
        return (r != 0) && (r % 2 == 0) && (r <= (32'd2 << fw));
    endfunction

    // Stored field is half the ratio minus one, so readback returns the ratio.
    function automatic int unsigned ratio_to_field(input int unsigned r);
        return (r >> 1) - 1;
    endfunction

    function automatic int unsigned round_even(input int unsigned r);
        return (r + 1) & ~32'd1;
    endfunction

endpackage

// File: rtl/ediv_req_check.sv
module ediv_req_check
    import even_clk_div_pkg::*;
#(
    parameter int FIELD_W = 5,
    parameter int RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               set_valid_i,
    input  logic [RATIO_W-1:0] set_ratio_i,
    output logic [FIELD_W-1:0] field_o,
    output req_st_e            st_o
);

    logic               legal;
    logic [FIELD_W-1:0] field_q;
    req_st_e            st_q;

    always_comb legal = ratio_legal(32'(set_ratio_i), FIELD_W);

    always_ff @(posedge clk) begin
        if (rst) begin
            field_q <= '0;
            st_q    <= ST_NONE;
        end else if (set_valid_i) begin
            if (legal) begin
                field_q <= FIELD_W'(ratio_to_field(32'(set_ratio_i)));
                st_q    <= ST_DONE;
            end else begin
                st_q    <= ST_REJ;
            end
        end else begin
            st_q <= ST_NONE;
        end
    end

    assign field_o = field_q;
    assign st_o    = st_q;

    // R4: an accepted request lands as half the ratio minus one
    p_accept_field_r4: assert property (@(posedge clk) disable iff (rst)
        (set_valid_i && legal) |=> (st_q == ST_DONE) &&
            (((RATIO_W'(field_q) + RATIO_W'(1)) << 1) == $past(set_ratio_i)));

    // R5, R6: a rejected request leaves the field alone
    p_reject_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (set_valid_i && !legal) |=> (st_q == ST_REJ) && $stable(field_q));

    // R9: without a request no status and no field change
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !set_valid_i |=> (st_q == ST_NONE) && $stable(field_q));

endmodule

// File: rtl/ediv_round.sv
module ediv_round
    import even_clk_div_pkg::*;
#(
    parameter int RATIO_W = 8
) (
    input  logic [RATIO_W-1:0] req_i,
    output logic [RATIO_W:0]   rate_o
);

    always_comb rate_o = (RATIO_W+1)'(round_even(32'(req_i)));

    // R8: result is even and never below the query
    always_comb begin
        p_round_even_r8: assert (rate_o[0] == 1'b0 && rate_o >= {1'b0, req_i});
    end

endmodule

// File: rtl/ediv_gen.sv
module ediv_gen #(
    parameter int FIELD_W = 5,
    parameter int RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [FIELD_W-1:0] field_i,
    output logic [RATIO_W-1:0] ratio_o,
    output logic               clk_div_o
);

    logic [FIELD_W-1:0] cnt_q;
    logic [FIELD_W-1:0] cur_n_q;
    logic               lvl_q;
    logic               half_end;
    logic [RATIO_W-1:0] half_len;

    assign half_end = (cnt_q == cur_n_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            cur_n_q <= '0;
            lvl_q   <= 1'b0;
        end else if (half_end) begin
            cnt_q <= '0;
            lvl_q <= ~lvl_q;
            if (!lvl_q) begin
                cur_n_q <= field_i;   // adopt only where the output rises
            end
        end else begin
            cnt_q <= cnt_q + FIELD_W'(1);
        end
    end

    always_comb half_len = RATIO_W'(cur_n_q) + RATIO_W'(1);
    assign ratio_o   = half_len << 1;
    assign clk_div_o = lvl_q;

    // R3: the phase counter never passes the phase length
    always_ff @(posedge clk) begin
        if (!rst) begin
            p_cnt_bound_r3: assert (cnt_q <= cur_n_q);
        end
    end

    // R7: the ratio in use changes only where the output rises
    p_switch_at_rise_r7: assert property (@(posedge clk) disable iff (rst)
        !(half_end && !lvl_q) |=> $stable(cur_n_q));

    // R3: mid-phase the output level holds
    p_level_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !half_end |=> $stable(lvl_q));

endmodule

// File: rtl/even_clk_div.sv
module even_clk_div
    import even_clk_div_pkg::*;
#(
    parameter int FIELD_W = 5,
    parameter int RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               set_valid,
    input  logic [RATIO_W-1:0] set_ratio,
    output logic               set_ok,
    output logic               set_err,
    output logic [FIELD_W-1:0] div_field,
    output logic [RATIO_W-1:0] active_ratio,
    input  logic [RATIO_W-1:0] round_req,
    output logic [RATIO_W:0]   round_rate,
    output logic               clk_div_o
);

    localparam int MAX_RATIO = 2 << FIELD_W;

    req_st_e            st;
    logic [FIELD_W-1:0] field;

    ediv_req_check #(.FIELD_W(FIELD_W), .RATIO_W(RATIO_W)) u_check (
        .clk         (clk),
        .rst         (rst),
        .set_valid_i (set_valid),
        .set_ratio_i (set_ratio),
        .field_o     (field),
        .st_o        (st)
    );

    ediv_gen #(.FIELD_W(FIELD_W), .RATIO_W(RATIO_W)) u_gen (
        .clk       (clk),
        .rst       (rst),
        .field_i   (field),
        .ratio_o   (active_ratio),
        .clk_div_o (clk_div_o)
    );

    ediv_round #(.RATIO_W(RATIO_W)) u_round (
        .req_i  (round_req),
        .rate_o (round_rate)
    );

    assign set_ok    = (st == ST_DONE);
    assign set_err   = (st == ST_REJ);
    assign div_field = field;

    // R9: the status outputs never both show
    p_status_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(set_ok && set_err));

    // R2: the ratio readback is even and within range
    p_ratio_range_r2: assert property (@(posedge clk) disable iff (rst)
        (active_ratio[0] == 1'b0) && (active_ratio >= RATIO_W'(2)) &&
        (int'(active_ratio) <= MAX_RATIO));

endmodule

// File: tb/even_clk_div_tb_top.sv
module even_clk_div_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int FW = 5;
    localparam int RW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          set_valid = 1'b0;
    logic [RW-1:0] set_ratio = '0;
    logic [RW-1:0] round_req = '0;
    logic          set_ok, set_err, clk_div_o;
    logic [FW-1:0] div_field;
    logic [RW-1:0] active_ratio;
    logic [RW:0]   round_rate;

    int n_chk = 0;
    int n_bad = 0;
    bit started = 0;
    bit done = 0;

    // reference state
    int m_field = 0, m_use = 0, m_left = 1, m_lvl = 0, m_ok = 0, m_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    even_clk_div #(.FIELD_W(FW), .RATIO_W(RW)) dut_i (
        .clk(clk), .rst(rst), .set_valid(set_valid), .set_ratio(set_ratio),
        .set_ok(set_ok), .set_err(set_err), .div_field(div_field),
        .active_ratio(active_ratio), .round_req(round_req),
        .round_rate(round_rate), .clk_div_o(clk_div_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // reference: half-period countdown, new ratio taken when the level rises
    always @(posedge clk) begin
        int prev_field;
        started = 1;
        if (rst) begin
            m_field = 0; m_use = 0; m_left = 1; m_lvl = 0; m_ok = 0; m_err = 0;
        end else begin
            prev_field = m_field;
            m_ok = 0; m_err = 0;
            if (set_valid) begin
                if (set_ratio != 0 && set_ratio % 2 == 0 && set_ratio <= 64) begin
                    m_field = set_ratio / 2 - 1;
                    m_ok = 1;
                end else begin
                    m_err = 1;
                end
            end
            m_left = m_left - 1;
            if (m_left == 0) begin
                if (m_lvl == 0) m_use = prev_field;
                m_lvl = 1 - m_lvl;
                m_left = m_use + 1;
            end
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            chk("R3 clk_div_o", int'(clk_div_o), m_lvl);
            chk("R2 active_ratio", int'(active_ratio), 2 * (m_use + 1));
            chk("R4 div_field", int'(div_field), m_field);
            chk("R4 set_ok", int'(set_ok), m_ok);
            chk("R5 set_err", int'(set_err), m_err);
        end
    end

    task automatic request(input int r);
        @(negedge clk);
        set_valid = 1'b1;
        set_ratio = RW'(r);
        @(negedge clk);
        set_valid = 1'b0;
        set_ratio = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rnd(input int q);
        round_req = RW'(q);
        #1;
        chk("R8 round_rate", int'(round_rate), ((q + 1) / 2) * 2);
    endtask

    task automatic wait_rise();
        logic prev;
        prev = clk_div_o;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!prev && clk_div_o) break;
            prev = clk_div_o;
        end
    endtask

    initial begin
        int fld;
        repeat (3) @(negedge clk);
        // R1: values held during reset
        chk("R1 clk_div_o", int'(clk_div_o), 0);
        chk("R1 div_field", int'(div_field), 0);
        chk("R1 active_ratio", int'(active_ratio), 2);
        chk("R1 status", int'(set_ok) + int'(set_err), 0);
        rst = 1'b0;
        idle(8);
        chk("R9 idle status", int'(set_ok) + int'(set_err), 0);

        request(6);
        chk("R4 field for 6", int'(div_field), 2);
        chk("R4 ok pulse", int'(set_ok), 1);
        idle(30);

        fld = int'(div_field);
        request(7);
        chk("R5 odd rejected", int'(set_err), 1);
        chk("R5 field kept", int'(div_field), fld);
        request(0);
        chk("R6 zero rejected", int'(set_err), 1);
        chk("R6 field kept", int'(div_field), fld);
        request(66);
        chk("R6 over-range rejected", int'(set_err), 1);
        chk("R6 field kept", int'(div_field), fld);
        idle(1);
        chk("R9 pulse ends", int'(set_err), 0);

        request(64);
        chk("R4 field for 64", int'(div_field), 31);
        idle(200);
        request(16);
        idle(60);
        wait_rise();
        idle(3);
        // R7: request mid-period, old ratio stays until the output rises
        request(10);
        request(4);
        chk("R7 field updated", int'(div_field), 1);
        chk("R7 old ratio still in use", int'(active_ratio), 16);
        wait_rise();
        chk("R7 new ratio at rise", int'(active_ratio), 4);
        idle(20);
        request(2);
        chk("R4 field for 2", int'(div_field), 0);
        idle(20);

        rnd(0); rnd(1); rnd(5); rnd(6); rnd(63); rnd(64); rnd(255);

        idle(2);
        rst = 1'b1;
        idle(2);
        chk("R1 reset again field", int'(div_field), 0);
        chk("R1 reset again ratio", int'(active_ratio), 2);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule